// File: doc/BRIEF.md
# Per-Channel Gain Code Combiner

This block forms the total gain control word for a two-stage amplifier chain. The first stage has a coarse code for each of four colour channels. The second stage has one fine code shared by all channels. Both work in a code domain where one step of either stage is about the same increment in dB. The block adds the code of the active channel to the shared code and clips the sum at a ceiling of 1023. That ceiling is the highest gain the chain may ever apply.

Software writes the codes through a simple write port. The four channel codes sit in two packed pair registers, and the shared code has a register of its own. Writes go into a shadow copy first. The copy becomes active only on a line-boundary strobe, so the gain never changes part way through a line. Each pixel arrives with a channel select. One cycle later the block presents the clipped total, together with a flag that shows whether clipping took place.

Top module: `gain_code_combiner`

## Requirements
- R1: Reset (synchronous, active high) clears every shadow and active code and drives `gain_valid`, `gain_code` and `gain_clip` to 0. A pixel after reset, with no commit in between, yields code 0 and no clip.
- R2: A write with `cfg_sel`=0 loads channel 0 from `cfg_wdata[8:0]` and channel 1 from `cfg_wdata[17:9]`. A write with `cfg_sel`=1 loads channel 2 and channel 3 from the same bit positions. A write with `cfg_sel`=2 loads the shared code from `cfg_wdata[9:0]` and ignores bits 17:10. A write with `cfg_sel`=3 changes nothing.
- R3: A written value does not affect any pixel result until a `line_sync` strobe has followed the write.
- R4: When a write and `line_sync` occur in the same cycle, the commit carries the shadow contents from before that write. The new value becomes active at the next `line_sync`.
- R5: A pixel presented in the same cycle as `line_sync` uses the codes that were active before that commit.
- R6: When the channel code plus the shared code is at most 1023, `gain_code` equals that sum and `gain_clip` is 0. A sum of exactly 1023 is not clipped.
- R7: When the sum exceeds 1023, `gain_code` is 1023 and `gain_clip` is 1.
- R8: `gain_valid` is high exactly one cycle after each cycle in which `pix_valid` is high. `gain_code` and `gain_clip` belong to that pixel in that same cycle, including for back-to-back pixels.
- R9: In a cycle after one with `pix_valid` low, `gain_valid` is 0 and `gain_code` and `gain_clip` keep their previous values.
- R10: `pix_chan` values 0 to 3 select the code of channel 0 to 3 for that pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 channel pair 0/1, 1 channel pair 2/3, 2 shared code, 3 none |
| cfg_wdata | input | 18 | Write data |
| line_sync | input | 1 | Line boundary strobe; copies the shadow codes to the active set |
| pix_valid | input | 1 | Pixel strobe |
| pix_chan | input | 2 | Channel of the current pixel |
| gain_valid | output | 1 | Result valid, one cycle after `pix_valid` |
| gain_code | output | 10 | Clipped total gain code |
| gain_clip | output | 1 | The total was clipped at 1023 |

## Verification
A corrupted active code shows at the ports on the first pixel of the affected channel after the faulty commit. It appears one cycle after that pixel, as a wrong `gain_code`. A shadow-to-active transfer at the wrong moment shows as a result that changes one pixel too early or too late around `line_sync`, so pixels are placed directly before, on and after the strobe. An off-by-one error in the clip compare shows only at sums of 1023 and 1024, so both values are driven on purpose.

// File: rtl/gcc_pkg.sv
`timescale 1ns/1ps
package gcc_pkg;
    localparam int NUM_CH    = 4;
    localparam int CH_W      = 9;
    localparam int MAIN_W    = 10;
    localparam int CHAN_W    = $clog2(NUM_CH);
    localparam int NUM_PAIRS = NUM_CH / 2;
    localparam int CFG_W     = 2 * CH_W;
    localparam int SEL_W     = $clog2(NUM_PAIRS + 2);
    localparam int SUM_W     = MAIN_W + 1;

    localparam logic [SEL_W-1:0]  SEL_MAIN  = SEL_W'(NUM_PAIRS);
    localparam logic [MAIN_W-1:0] CODE_CEIL = '1;

    typedef logic [CH_W-1:0]   ch_code_t;
    typedef logic [MAIN_W-1:0] main_code_t;

    typedef struct packed {
        ch_code_t [NUM_CH-1:0] ch;
        main_code_t            main;
    } gain_set_t;

    typedef struct packed {
        logic       clip;
        main_code_t code;
    } gain_res_t;

    function automatic gain_res_t sat_total(input ch_code_t c, input main_code_t m);
        gain_res_t        res;
        logic [SUM_W-1:0] s;
        s        = SUM_W'(c) + SUM_W'(m);
        res.clip = (s > SUM_W'(CODE_CEIL));
        res.code = res.clip ? CODE_CEIL : s[MAIN_W-1:0];
        return res;
    endfunction
endpackage

// File: rtl/gcc_cfg_bank.sv
`timescale 1ns/1ps
module gcc_cfg_bank
    import gcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             line_sync,
    output gain_set_t        act
);
    ch_code_t [NUM_CH-1:0] shd_ch;
    ch_code_t [NUM_CH-1:0] nxt_ch;
    main_code_t            shd_main;

    // Each pair register feeds one even and one odd channel code.
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        logic hit;
        assign hit             = cfg_wr && (cfg_sel == SEL_W'(p));
        assign nxt_ch[2*p]     = hit ? cfg_wdata[CH_W-1:0]      : shd_ch[2*p];
        assign nxt_ch[2*p + 1] = hit ? cfg_wdata[2*CH_W-1:CH_W] : shd_ch[2*p + 1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shd_ch   <= '0;
            shd_main <= '0;
            act      <= '0;
        end else begin
            shd_ch <= nxt_ch;
            if (cfg_wr && cfg_sel == SEL_MAIN)
                shd_main <= cfg_wdata[MAIN_W-1:0];
            if (line_sync) begin
                act.ch   <= shd_ch;
                act.main <= shd_main;
            end
        end
    end
endmodule

// File: rtl/gcc_chan_sel.sv
`timescale 1ns/1ps
module gcc_chan_sel
    import gcc_pkg::*;
(
    input  gain_set_t         act,
    input  logic [CHAN_W-1:0] chan,
    output ch_code_t          ch_code,
    output main_code_t        main_code
);
    assign ch_code   = act.ch[chan];
    assign main_code = act.main;
endmodule

// File: rtl/gcc_sat_stage.sv
`timescale 1ns/1ps
module gcc_sat_stage
    import gcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pix_valid,
    input  ch_code_t   ch_code,
    input  main_code_t main_code,
    output logic       gain_valid,
    output main_code_t gain_code,
    output logic       gain_clip
);
    gain_res_t res;

    always_comb res = sat_total(ch_code, main_code);

    always_ff @(posedge clk) begin
        if (rst) begin
            gain_valid <= 1'b0;
            gain_code  <= '0;
            gain_clip  <= 1'b0;
        end else begin
            gain_valid <= pix_valid;
            if (pix_valid) begin
                gain_code <= res.code;
                gain_clip <= res.clip;
            end
        end
    end
endmodule

// File: rtl/gain_code_combiner.sv
`timescale 1ns/1ps
module gain_code_combiner
    import gcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              line_sync,
    input  logic              pix_valid,
    input  logic [CHAN_W-1:0] pix_chan,
    output logic              gain_valid,
    output logic [MAIN_W-1:0] gain_code,
    output logic              gain_clip
);
    gain_set_t  act_set;
    ch_code_t   sel_ch;
    main_code_t sel_main;

    gcc_cfg_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .line_sync (line_sync),
        .act       (act_set)
    );

    gcc_chan_sel u_sel (
        .act       (act_set),
        .chan      (pix_chan),
        .ch_code   (sel_ch),
        .main_code (sel_main)
    );

    gcc_sat_stage u_sat (
        .clk        (clk),
        .rst        (rst),
        .pix_valid  (pix_valid),
        .ch_code    (sel_ch),
        .main_code  (sel_main),
        .gain_valid (gain_valid),
        .gain_code  (gain_code),
        .gain_clip  (gain_clip)
    );
endmodule

// File: rtl/gcc_chk.sv
`timescale 1ns/1ps
module gcc_chk
    import gcc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              line_sync,
    input logic              pix_valid,
    input logic [CHAN_W-1:0] pix_chan,
    input logic              gain_valid,
    input logic [MAIN_W-1:0] gain_code,
    input logic              gain_clip,
    input gain_set_t         act
);
    logic [SUM_W-1:0] want_sum;
    logic             rst_q;

    always_comb want_sum = SUM_W'(act.ch[pix_chan]) + SUM_W'(act.main);

    always_ff @(posedge clk) rst_q <= rst;

    // R1: outputs cleared in the cycle after a reset edge
    always_ff @(posedge clk) begin
        if (rst_q == 1'b1)
            a_r1_reset_clear : assert (!gain_valid && gain_code == '0 && !gain_clip);
    end

    a_r8_valid_follows : assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> gain_valid);

    a_r9_no_spurious_valid : assert property (@(posedge clk) disable iff (rst)
        !pix_valid |=> !gain_valid);

    a_r9_hold_result : assert property (@(posedge clk) disable iff (rst)
        !pix_valid |=> ($stable(gain_code) && $stable(gain_clip)));

    a_r7_clip_at_ceiling : assert property (@(posedge clk) disable iff (rst)
        gain_clip |-> gain_code == CODE_CEIL);

    a_r7_clip_when_over : assert property (@(posedge clk) disable iff (rst)
        (pix_valid && want_sum > SUM_W'(CODE_CEIL)) |=> gain_clip);

    a_r6_plain_sum : assert property (@(posedge clk) disable iff (rst)
        (pix_valid && want_sum <= SUM_W'(CODE_CEIL))
            |=> (gain_code == $past(want_sum[MAIN_W-1:0]) && !gain_clip));

    a_r3_commit_only_at_line : assert property (@(posedge clk) disable iff (rst)
        !line_sync |=> $stable(act));
endmodule

bind gain_code_combiner gcc_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .line_sync  (line_sync),
    .pix_valid  (pix_valid),
    .pix_chan   (pix_chan),
    .gain_valid (gain_valid),
    .gain_code  (gain_code),
    .gain_clip  (gain_clip),
    .act        (act_set)
);

// File: tb/sim_gain_code_combiner.sv
`timescale 1ns/1ps
module sim_gain_code_combiner;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [17:0] cfg_wdata = '0;
    logic        line_sync = 1'b0;
    logic        pix_valid = 1'b0;
    logic [1:0]  pix_chan = '0;
    logic        gain_valid;
    logic [9:0]  gain_code;
    logic        gain_clip;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gain_code_combiner u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .line_sync(line_sync), .pix_valid(pix_valid),
        .pix_chan(pix_chan), .gain_valid(gain_valid), .gain_code(gain_code),
        .gain_clip(gain_clip)
    );

    typedef struct packed {
        logic [8:0] c0, c1, c2, c3;
        logic [9:0] main;
        logic [1:0] chan;
        logic [9:0] exp_code;
        logic       exp_clip;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{9'd0,   9'd0,   9'd0,   9'd0,   10'd0,    2'd0, 10'd0,    1'b0},
        '{9'd100, 9'd200, 9'd300, 9'd400, 10'd500,  2'd1, 10'd700,  1'b0},
        '{9'd100, 9'd200, 9'd300, 9'd400, 10'd500,  2'd3, 10'd900,  1'b0},
        '{9'd511, 9'd0,   9'd0,   9'd0,   10'd512,  2'd0, 10'd1023, 1'b0},
        '{9'd511, 9'd0,   9'd0,   9'd0,   10'd513,  2'd0, 10'd1023, 1'b1},
        '{9'd511, 9'd511, 9'd511, 9'd511, 10'd1023, 2'd2, 10'd1023, 1'b1},
        '{9'd0,   9'd1,   9'd0,   9'd0,   10'd1023, 2'd1, 10'd1023, 1'b1},
        '{9'd12,  9'd34,  9'd56,  9'd78,  10'd900,  2'd2, 10'd956,  1'b0},
        '{9'd300, 9'd0,   9'd0,   9'd0,   10'd723,  2'd0, 10'd1023, 1'b0},
        '{9'd300, 9'd0,   9'd0,   9'd0,   10'd724,  2'd0, 10'd1023, 1'b1}
    };

    task automatic check(input string req, input logic [9:0] exp_code,
                         input logic exp_clip, input logic exp_valid);
        checks++;
        if (gain_code !== exp_code || gain_clip !== exp_clip || gain_valid !== exp_valid) begin
            errors++;
            $display("FAIL %s: code=%0d clip=%0b valid=%0b expected code=%0d clip=%0b valid=%0b",
                     req, gain_code, gain_clip, gain_valid, exp_code, exp_clip, exp_valid);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [17:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic sync_line();
        @(negedge clk);
        line_sync = 1'b1;
        @(negedge clk);
        line_sync = 1'b0;
    endtask

    task automatic load(input logic [8:0] c0, c1, c2, c3, input logic [9:0] m);
        wr(2'd0, {c1, c0});
        wr(2'd1, {c3, c2});
        wr(2'd2, {8'd0, m});
        sync_line();
    endtask

    task automatic pix(input logic [1:0] ch, input logic [9:0] exp_code,
                       input logic exp_clip, input string req);
        @(negedge clk);
        pix_valid = 1'b1; pix_chan = ch;
        @(negedge clk);
        pix_valid = 1'b0;
        check(req, exp_code, exp_clip, 1'b1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset outputs", 10'd0, 1'b0, 1'b0);
        pix(2'd3, 10'd0, 1'b0, "R1 codes zero after reset");

        // Table walk: sums, clipping and channel selection (R6 R7 R10)
        for (int i = 0; i < NV; i++) begin
            load(VECS[i].c0, VECS[i].c1, VECS[i].c2, VECS[i].c3, VECS[i].main);
            pix(VECS[i].chan, VECS[i].exp_code, VECS[i].exp_clip,
                $sformatf("R6 R7 R10 vector %0d", i));
        end

        // R8: back-to-back pixels
        load(9'd10, 9'd20, 9'd30, 9'd40, 10'd100);
        @(negedge clk);
        pix_valid = 1'b1; pix_chan = 2'd0;
        @(negedge clk);
        pix_chan = 2'd1;
        check("R8 first of pair", 10'd110, 1'b0, 1'b1);
        @(negedge clk);
        pix_valid = 1'b0;
        check("R8 second of pair", 10'd120, 1'b0, 1'b1);

        // R9: idle cycles hold the result with valid low
        @(negedge clk);
        check("R9 idle hold", 10'd120, 1'b0, 1'b0);
        @(negedge clk);
        check("R9 idle hold again", 10'd120, 1'b0, 1'b0);

        // R3: write without commit is not visible
        wr(2'd2, 18'd200);
        pix(2'd0, 10'd110, 1'b0, "R3 before commit");
        sync_line();
        pix(2'd0, 10'd210, 1'b0, "R3 after commit");

        // R4: write in the same cycle as line_sync waits for the next one
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = 2'd2; cfg_wdata = 18'd300; line_sync = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; line_sync = 1'b0;
        pix(2'd0, 10'd210, 1'b0, "R4 same-cycle write deferred");
        sync_line();
        pix(2'd0, 10'd310, 1'b0, "R4 next commit");

        // R5: pixel on the commit cycle sees the old codes
        wr(2'd2, 18'd400);
        @(negedge clk);
        line_sync = 1'b1; pix_valid = 1'b1; pix_chan = 2'd0;
        @(negedge clk);
        line_sync = 1'b0; pix_valid = 1'b0;
        check("R5 pixel on commit cycle", 10'd310, 1'b0, 1'b1);
        pix(2'd0, 10'd410, 1'b0, "R5 following pixel");

        // R2: select 3 ignored, packing of pairs, upper bits of shared code ignored
        wr(2'd3, 18'h3FFFF);
        sync_line();
        pix(2'd0, 10'd410, 1'b0, "R2 sel3 ch0");
        pix(2'd1, 10'd420, 1'b0, "R2 sel3 ch1");
        pix(2'd2, 10'd430, 1'b0, "R2 sel3 ch2");
        pix(2'd3, 10'd440, 1'b0, "R2 sel3 ch3");
        wr(2'd2, {8'hFF, 10'd5});
        sync_line();
        pix(2'd1, 10'd25, 1'b0, "R2 shared code upper bits ignored");

        // R1: reset from a clipped state
        load(9'd10, 9'd20, 9'd30, 9'd40, 10'd1023);
        pix(2'd3, 10'd1023, 1'b1, "R7 clip before reset");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset clears outputs", 10'd0, 1'b0, 1'b0);
        sync_line();
        pix(2'd3, 10'd0, 1'b0, "R1 reset clears codes");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule